// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block watches the access streams of the two ports of a shared dual-port memory and keeps one interrupt flag per port. Each port presents a valid strobe, a write/read indication, an address and a busy input. The two highest addresses work as mailboxes. The top address belongs to the right port and the address just below it belongs to the left port. When one port writes into the other port's mailbox, the other port's interrupt is raised. The interrupt stays up until its owner reads its own mailbox.

A port whose busy input is active can neither raise the other port's interrupt nor clear its own. The block does not store the mailbox contents and does not arbitrate the memory. It only tracks the two flags, and each flag drives an active-low interrupt output. The address width is a parameter.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset both interrupt outputs are high, which is the inactive level.
- R2: A valid write by the left port to the top address (all ones) drives r_irq_no low on the first clock edge after the access.
- R3: A valid write by the right port to the address one below the top drives l_irq_no low on the first clock edge after the access.
- R4: A raised interrupt stays low until its owner makes a valid read of its own mailbox. The owner's mailbox is the top address for the right port and top minus one for the left port. That read returns the output to high on the next clock edge.
- R5: A read by a port of the other port's mailbox leaves both outputs unchanged.
- R6: Three kinds of access leave both outputs unchanged: a port writing its own mailbox, an access to any non-mailbox address, and an access presented with the valid strobe low.
- R7: While a port's busy input is high, a write by that port to the other port's mailbox does not raise the other port's interrupt.
- R8: While a port's busy input is high, a read by that port of its own mailbox does not clear its interrupt.
- R9: If one port sets a flag and the owner clears the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_valid_i | input | 1 | Left port access strobe |
| l_write_i | input | 1 | Left port access is a write when high, a read when low |
| l_addr_i | input | AW | Left port address |
| l_busy_i | input | 1 | Left port busy, blocks its set and clear |
| r_valid_i | input | 1 | Right port access strobe |
| r_write_i | input | 1 | Right port access is a write when high, a read when low |
| r_addr_i | input | AW | Right port address |
| r_busy_i | input | 1 | Right port busy, blocks its set and clear |
| l_irq_no | output | 1 | Left port interrupt, active low |
| r_irq_no | output | 1 | Right port interrupt, active low |

## Verification
The in-RTL assertions check four things on every cycle:
- a qualified set is visible one cycle later;
- a lone clear drops the flag;
- with no request the flag holds;
- a set beats a simultaneous clear, and busy suppresses the decoded requests.

Some behaviour depends on which addresses and directions reach the decoder. Writes to a port's own mailbox, reads of the other port's mailbox, off-mailbox addresses and a low strobe all fall in this group. These cases, together with both flags moving at once, are shown only by the bench's directed scenarios against its cycle-level model.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  typedef enum logic {
    PORT_L = 1'b0,
    PORT_R = 1'b1
  } port_e;

  localparam int unsigned NUM_PORTS = 2;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_irq_pkg::*;
#(
  parameter int unsigned AW    = 14,
  parameter port_e       OWNER = PORT_L
) (
  input  logic          valid_i,
  input  logic          write_i,
  input  logic [AW-1:0] addr_i,
  input  logic          busy_i,
  output logic          set_peer_o,
  output logic          clr_own_o
);
  localparam logic [AW-1:0] TOP_ADDR  = {AW{1'b1}};
  localparam logic [AW-1:0] NEXT_ADDR = TOP_ADDR - 1'b1;
  localparam logic [AW-1:0] OWN_ADDR  = (OWNER == PORT_R) ? TOP_ADDR : NEXT_ADDR;
  localparam logic [AW-1:0] PEER_ADDR = (OWNER == PORT_R) ? NEXT_ADDR : TOP_ADDR;

  logic hit_own, hit_peer, go;

  assign go         = valid_i & ~busy_i;
  assign hit_own    = (addr_i == OWN_ADDR);
  assign hit_peer   = (addr_i == PEER_ADDR);
  assign set_peer_o = go & write_i & hit_peer;
  assign clr_own_o  = go & ~write_i & hit_own;

  always_comb begin
    p_busy_no_set_r7: assert (!(busy_i && set_peer_o));
    p_busy_no_clr_r8: assert (!(busy_i && clr_own_o));
    p_excl_r6: assert (!(set_peer_o && clr_own_o));
  end
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;  // set has priority
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign irq_no = ~flag_q;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !irq_no);
  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> irq_no);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(irq_no));
  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> !irq_no);
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int unsigned AW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_valid_i,
  input  logic          l_write_i,
  input  logic [AW-1:0] l_addr_i,
  input  logic          l_busy_i,
  input  logic          r_valid_i,
  input  logic          r_write_i,
  input  logic [AW-1:0] r_addr_i,
  input  logic          r_busy_i,
  output logic          l_irq_no,
  output logic          r_irq_no
);
  logic [NUM_PORTS-1:0]         valid, write, busy, set_peer, clr_own, irq_n;
  logic [NUM_PORTS-1:0][AW-1:0] addr;

  assign valid = {r_valid_i, l_valid_i};
  assign write = {r_write_i, l_write_i};
  assign busy  = {r_busy_i,  l_busy_i};
  assign addr  = {r_addr_i,  l_addr_i};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam port_e OWN  = port_e'(p);
    localparam int    PEER = NUM_PORTS - 1 - p;

    mbox_decode #(.AW(AW), .OWNER(OWN)) u_dec (
      .valid_i    (valid[p]),
      .write_i    (write[p]),
      .addr_i     (addr[p]),
      .busy_i     (busy[p]),
      .set_peer_o (set_peer[p]),
      .clr_own_o  (clr_own[p])
    );

    // flag of port p is set by the peer and cleared by its owner
    mbox_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_peer[PEER]),
      .clr_i  (clr_own[p]),
      .irq_no (irq_n[p])
    );
  end

  assign l_irq_no = irq_n[PORT_L];
  assign r_irq_no = irq_n[PORT_R];

  p_r_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_valid_i && l_write_i && !l_busy_i && (l_addr_i == {AW{1'b1}})) |=> !r_irq_no);
  p_l_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r_valid_i && r_write_i && !r_busy_i && (r_addr_i == {{(AW-1){1'b1}}, 1'b0})) |=> !l_irq_no);
  p_r_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !l_valid_i |=> ($rose(r_irq_no) || $stable(r_irq_no)));
endmodule

// File: tb/mbox_irq_ctrl_test.sv
module mbox_irq_ctrl_test;
  localparam int unsigned AW = 14;
  localparam logic [AW-1:0] TOPA = {AW{1'b1}};
  localparam logic [AW-1:0] NXTA = TOPA - 1'b1;

  typedef struct {
    logic  l_n;
    logic  r_n;
    string tag;
  } exp_t;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic l_valid_i = 0, l_write_i = 0, l_busy_i = 0;
  logic r_valid_i = 0, r_write_i = 0, r_busy_i = 0;
  logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
  logic l_irq_no, r_irq_no;

  int checks = 0, errors = 0;
  logic mf_l = 0, mf_r = 0;  // model flags, active high
  exp_t q[$];

  always #10 clk_i = ~clk_i;

  mbox_irq_ctrl #(.AW(AW)) uut (
    .clk_i, .rst_ni,
    .l_valid_i, .l_write_i, .l_addr_i, .l_busy_i,
    .r_valid_i, .r_write_i, .r_addr_i, .r_busy_i,
    .l_irq_no, .r_irq_no
  );

  task automatic acc(input logic lv, input logic lw, input logic [AW-1:0] la, input logic lb,
                     input logic rv, input logic rw, input logic [AW-1:0] ra, input logic rb,
                     input string tag);
    logic set_r, clr_r, set_l, clr_l;
    exp_t e;
    @(negedge clk_i);
    l_valid_i = lv; l_write_i = lw; l_addr_i = la; l_busy_i = lb;
    r_valid_i = rv; r_write_i = rw; r_addr_i = ra; r_busy_i = rb;
    set_r = lv && lw && !lb && (la == TOPA);
    clr_l = lv && !lw && !lb && (la == NXTA);
    set_l = rv && rw && !rb && (ra == NXTA);
    clr_r = rv && !rw && !rb && (ra == TOPA);
    mf_r = set_r | (mf_r & ~clr_r);
    mf_l = set_l | (mf_l & ~clr_l);
    e.l_n = ~mf_l; e.r_n = ~mf_r; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    acc(0, 0, '0, 0, 0, 0, '0, 0, tag);
  endtask

  // monitor: sample 5 ns after each rising edge
  always @(posedge clk_i) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (l_irq_no !== e.l_n || r_irq_no !== e.r_n) begin
        errors++;
        $display("FAIL %s: l_irq_no=%b r_irq_no=%b expected %b %b",
                 e.tag, l_irq_no, r_irq_no, e.l_n, e.r_n);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (l_irq_no !== 1'b1 || r_irq_no !== 1'b1) begin
      errors++;
      $display("FAIL R1 in reset: %b %b expected 1 1", l_irq_no, r_irq_no);
    end
    rst_ni = 1'b1;
    idle("R1 after reset");
    acc(1, 1, TOPA, 0, 0, 0, '0, 0, "R2 left writes right mailbox");
    idle("R4 flag holds");
    acc(1, 0, TOPA, 0, 0, 0, '0, 0, "R5 left reads right mailbox");
    acc(0, 0, '0, 0, 1, 1, TOPA, 0, "R6 right writes own mailbox");
    acc(0, 0, '0, 0, 1, 0, NXTA, 0, "R5 right reads left mailbox");
    acc(0, 0, '0, 0, 1, 0, TOPA, 1, "R8 busy right read");
    acc(0, 0, '0, 0, 1, 0, TOPA, 0, "R4 right clears own");
    acc(0, 0, '0, 0, 1, 1, NXTA, 0, "R3 right writes left mailbox");
    acc(1, 0, NXTA, 1, 0, 0, '0, 0, "R8 busy left read");
    acc(1, 1, NXTA, 0, 0, 0, '0, 0, "R6 left writes own mailbox");
    acc(1, 0, NXTA, 0, 0, 0, '0, 0, "R4 left clears own");
    acc(1, 1, TOPA, 1, 0, 0, '0, 0, "R7 busy left write");
    acc(0, 0, '0, 0, 1, 1, NXTA, 1, "R7 busy right write");
    acc(1, 1, 14'd5, 0, 1, 1, 14'd6, 0, "R6 non-mailbox writes");
    acc(0, 1, TOPA, 0, 0, 1, NXTA, 0, "R6 valid low");
    acc(1, 1, TOPA, 0, 1, 1, NXTA, 0, "R2 R3 both set");
    acc(1, 1, TOPA, 0, 1, 0, TOPA, 0, "R9 set beats clear right");
    acc(1, 0, NXTA, 0, 1, 1, NXTA, 0, "R9 set beats clear left");
    acc(1, 0, NXTA, 0, 1, 0, TOPA, 0, "R4 both clear");
    acc(1, 0, TOPA, 0, 1, 0, NXTA, 0, "R5 cross reads idle");
    idle("R4 final idle");
    idle("R1 drain");
    wait (q.size() == 0);
    @(negedge clk_i);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule